// File: doc/BRIEF.md
# Per-Word Chip-Select Controller for an SPI Master

This block drives the chip-select lines of an SPI master whose target peripheral is chosen word by word. Each transmit word carries a right-justified character, a peripheral select code and a flag that marks the last word of a burst. The block turns the select code into a pattern on two active-low chip-select lines. It then asks an external shift engine to move the character and waits for that engine to report completion.

Two mode inputs set how the select code is used. With decoding off, a fixed one-hot map applies. With decoding on, the low code bits go straight to the lines. When the per-word select mode is off, a static select input replaces the code field and the last flag has no effect. When hold-after-transfer is enabled, the selected line stays low between words until a word flagged as last completes. If a held line must give way to a different pattern, it first goes high for one clock.

The controller has five states. IDLE has no line selected and accepts a word (IDLE→SETUP). SETUP drives the new pattern and pulses the start strobe (SETUP→SHIFT). SHIFT waits for done and then moves to HOLD (hold enabled, not last) or to IDLE (otherwise). HOLD keeps the line low and accepts a word: HOLD→SETUP when the pattern is the same, HOLD→GAP when it differs. GAP drives both lines high for one clock (GAP→SETUP).

Top module: `xcs_ctrl`

## Requirements
- R1: The transmit word holds the character in bits 15:0 (right-justified), the select code in bits 19:16 and the last flag in bit 24. The character is presented on `sh_data` while `sh_start` is high.
- R2: When `var_sel_en` is 0, `fixed_sel` supplies the select code, and bits 19:16 and bit 24 of the word have no effect on the lines.
- R3: With `dec_en` = 0, a code whose bit 0 is 0 gives `cs_n` = 2'b10, and code bits 1:0 = 2'b01 give `cs_n` = 2'b01. Code bits 1:0 = 2'b11 select nothing, so `cs_n` = 2'b11.
- R4: With `dec_en` = 1, `cs_n` equals code bits 1:0.
- R5: A word is accepted when `wr_valid` and `wr_ready` are both high. In the next cycle `cs_n` shows the new pattern and `sh_start` is high for exactly one cycle. `wr_ready` is high only while no transfer is in progress.
- R6: With `hold_en` = 0, `cs_n` returns to 2'b11 in the cycle after `sh_done`, whatever the last flag says.
- R7: With `hold_en` = 1, `cs_n` keeps its pattern after `sh_done` until a word with the last flag set (and `var_sel_en` = 1) completes. After that word, `cs_n` becomes 2'b11 in the next cycle.
- R8: A held pattern never changes directly into a different selecting pattern. `cs_n` is 2'b11 for at least one cycle in between.
- R9: During and after reset, `cs_n` = 2'b11, `sh_start` = 0 and `wr_ready` = 1.
- R10: `sh_done` has no effect unless a shift is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Transmit word offered |
| wr_word | input | 32 | Transmit word |
| wr_ready | output | 1 | Controller can take a word |
| var_sel_en | input | 1 | Select code and last flag taken from each word |
| dec_en | input | 1 | Drive code bits straight onto the lines |
| fixed_sel | input | 4 | Select code used when per-word select is off |
| hold_en | input | 1 | Keep the line low between words |
| sh_start | output | 1 | One-cycle request to the shift engine |
| sh_data | output | 16 | Character for the shift engine |
| sh_done | input | 1 | Shift engine finished the character |
| cs_n | output | 2 | Active-low chip-select lines |

## Verification
On every cycle, the assertions check that the start strobe lasts one cycle and never coincides with `wr_ready`. They also check the release after a done without hold, the kept pattern after a done with hold, the absence of a direct switch between two selecting patterns, and the forbidden-code map of the decoder. Only the bench scenarios can show that the mode inputs, the code field and the last flag produce the right patterns. The same holds for the closing of a held burst, stray done pulses being ignored and the character reaching the shift engine. These are covered by a cycle-by-cycle reference model.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
    localparam int XCS_WORD_W   = 32;
    localparam int XCS_DATA_W   = 16;
    localparam int XCS_SEL_W    = 4;
    localparam int XCS_SEL_LSB  = 16;
    localparam int XCS_LAST_BIT = 24;
    localparam int XCS_CS_W     = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_SHIFT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } xcs_state_e;
endpackage

// File: rtl/xcs_word_split.sv
module xcs_word_split
    import xcs_pkg::*;
#(
    parameter int WORD_W   = XCS_WORD_W,
    parameter int DATA_W   = XCS_DATA_W,
    parameter int SEL_W    = XCS_SEL_W,
    parameter int SEL_LSB  = XCS_SEL_LSB,
    parameter int LAST_BIT = XCS_LAST_BIT
) (
    input  logic [WORD_W-1:0] word,
    input  logic              var_sel_en,
    input  logic [SEL_W-1:0]  fixed_sel,
    output logic [DATA_W-1:0] data,
    output logic [SEL_W-1:0]  code,
    output logic              last
);
    localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

    logic unused_word_bits;

    always_comb begin
        data = word[DATA_W-1:0];
        if (var_sel_en) begin
            code = word[SEL_MSB:SEL_LSB];
            last = word[LAST_BIT];
        end else begin
            code = fixed_sel;
            last = 1'b0;
        end
    end

    assign unused_word_bits = ^{word[WORD_W-1:LAST_BIT+1], word[LAST_BIT-1:SEL_MSB+1]};
endmodule

// File: rtl/xcs_cs_map.sv
module xcs_cs_map
    import xcs_pkg::*;
#(
    parameter int SEL_W = XCS_SEL_W,
    parameter int CS_W  = XCS_CS_W
) (
    input  logic [SEL_W-1:0] code,
    input  logic             dec_en,
    output logic [CS_W-1:0]  pattern
);
    logic [CS_W-1:0] onehot_n;
    logic            unused_code_bits;

    genvar i;
    generate
        for (i = 0; i < CS_W; i++) begin : g_line
            if (i == 0) begin : g_first
                assign onehot_n[i] = code[0];
            end else begin : g_next
                assign onehot_n[i] = !((&code[i-1:0]) && !code[i]);
            end
        end
        if (SEL_W > CS_W) begin : g_spare
            assign unused_code_bits = ^code[SEL_W-1:CS_W];
        end else begin : g_nospare
            assign unused_code_bits = 1'b0;
        end
    endgenerate

    assign pattern = dec_en ? code[CS_W-1:0] : onehot_n;

    always_comb begin
        if (!dec_en && (&code[CS_W-1:0])) begin
            p_forbidden_code_r3: assert (pattern == {CS_W{1'b1}})
                else $error("forbidden code selected a line");
        end
    end
endmodule

// File: rtl/xcs_fsm.sv
module xcs_fsm
    import xcs_pkg::*;
#(
    parameter int DATA_W = XCS_DATA_W,
    parameter int CS_W   = XCS_CS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CS_W-1:0]   pat_in,
    input  logic              last_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              hold_en,
    input  logic              sh_done,
    output logic              wr_ready,
    output logic              sh_start,
    output logic [DATA_W-1:0] sh_data,
    output logic [CS_W-1:0]   cs_n
);
    localparam logic [CS_W-1:0] NONE = {CS_W{1'b1}};

    xcs_state_e        state_q, state_d;
    logic [CS_W-1:0]   pat_q;
    logic              last_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign accept = wr_valid && wr_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_valid) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) state_d = (hold_en && !last_q) ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (wr_valid) state_d = (pat_in == pat_q) ? ST_SETUP : ST_GAP;
            ST_GAP:   state_d = ST_SETUP;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pat_q   <= NONE;
            last_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pat_q  <= pat_in;
                last_q <= last_in;
                data_q <= data_in;
            end
        end
    end

    always_comb begin
        wr_ready = 1'b0;
        sh_start = 1'b0;
        cs_n     = NONE;
        unique case (state_q)
            ST_IDLE:  wr_ready = 1'b1;
            ST_SETUP: begin
                sh_start = 1'b1;
                cs_n     = pat_q;
            end
            ST_SHIFT: cs_n = pat_q;
            ST_HOLD: begin
                wr_ready = 1'b1;
                cs_n     = pat_q;
            end
            ST_GAP:   cs_n = NONE;
            default:  cs_n = NONE;
        endcase
    end

    assign sh_data = data_q;

    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);

    p_start_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !wr_ready);

    p_release_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sh_done && !hold_en) |=> (cs_n == NONE));

    p_keep_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sh_done && hold_en && !last_q) |=> (cs_n == $past(cs_n)));

    p_switch_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != NONE && $past(cs_n) != NONE) |-> (cs_n == $past(cs_n)));
endmodule

// File: rtl/xcs_ctrl.sv
module xcs_ctrl
    import xcs_pkg::*;
#(
    parameter int WORD_W   = XCS_WORD_W,
    parameter int DATA_W   = XCS_DATA_W,
    parameter int SEL_W    = XCS_SEL_W,
    parameter int SEL_LSB  = XCS_SEL_LSB,
    parameter int LAST_BIT = XCS_LAST_BIT,
    parameter int CS_W     = XCS_CS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    output logic              wr_ready,
    input  logic              var_sel_en,
    input  logic              dec_en,
    input  logic [SEL_W-1:0]  fixed_sel,
    input  logic              hold_en,
    output logic              sh_start,
    output logic [DATA_W-1:0] sh_data,
    input  logic              sh_done,
    output logic [CS_W-1:0]   cs_n
);
    logic [DATA_W-1:0] w_data;
    logic [SEL_W-1:0]  w_code;
    logic              w_last;
    logic [CS_W-1:0]   w_pat;

    xcs_word_split #(
        .WORD_W(WORD_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .SEL_LSB(SEL_LSB), .LAST_BIT(LAST_BIT)
    ) i_split (
        .word(wr_word), .var_sel_en(var_sel_en), .fixed_sel(fixed_sel),
        .data(w_data), .code(w_code), .last(w_last)
    );

    xcs_cs_map #(.SEL_W(SEL_W), .CS_W(CS_W)) i_map (
        .code(w_code), .dec_en(dec_en), .pattern(w_pat)
    );

    xcs_fsm #(.DATA_W(DATA_W), .CS_W(CS_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .pat_in(w_pat),
        .last_in(w_last), .data_in(w_data), .hold_en(hold_en), .sh_done(sh_done),
        .wr_ready(wr_ready), .sh_start(sh_start), .sh_data(sh_data), .cs_n(cs_n)
    );
endmodule

// File: tb/test_xcs_ctrl.sv
module test_xcs_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_word = '0;
    logic        wr_ready;
    logic        var_sel_en = 1'b1;
    logic        dec_en = 1'b0;
    logic [3:0]  fixed_sel = 4'd0;
    logic        hold_en = 1'b0;
    logic        sh_start;
    logic [15:0] sh_data;
    logic        sh_done = 1'b0;
    logic [1:0]  cs_n;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R9";
    bit    stray = 1'b0;
    int    shift_left = 0;

    int          m_ph = 0;
    logic [1:0]  m_cs = 2'b11;
    logic [15:0] m_data = '0;
    bit          m_last = 1'b0;

    always #5 clk = ~clk;

    xcs_ctrl i_xcs_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_ready(wr_ready), .var_sel_en(var_sel_en), .dec_en(dec_en),
        .fixed_sel(fixed_sel), .hold_en(hold_en), .sh_start(sh_start),
        .sh_data(sh_data), .sh_done(sh_done), .cs_n(cs_n)
    );

    function automatic logic [1:0] ref_map(input logic [3:0] code, input bit dec);
        if (dec) return code[1:0];
        case (code[1:0])
            2'b00, 2'b10: return 2'b10;
            2'b01:        return 2'b01;
            default:      return 2'b11;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: one step per rising edge
    always @(posedge clk) begin
        logic [3:0]  code;
        logic [1:0]  np;
        if (!rst_n) begin
            m_ph = 0; m_cs = 2'b11; m_last = 1'b0; m_data = '0;
        end else begin
            code = var_sel_en ? wr_word[19:16] : fixed_sel;
            np   = ref_map(code, dec_en);
            case (m_ph)
                0: if (wr_valid) begin
                       m_cs = np; m_data = wr_word[15:0];
                       m_last = var_sel_en && wr_word[24]; m_ph = 1;
                   end
                1: m_ph = 2;
                2: if (sh_done) m_ph = (hold_en && !m_last) ? 3 : 0;
                3: if (wr_valid) begin
                       m_ph = (np == m_cs) ? 1 : 4;
                       m_cs = np; m_data = wr_word[15:0];
                       m_last = var_sel_en && wr_word[24];
                   end
                default: m_ph = 1;
            endcase
        end
    end

    // Compare and drive the shift engine at the falling edge
    always @(negedge clk) begin
        logic [1:0] ecs;
        if (rst_n) begin
            ecs = (m_ph >= 1 && m_ph <= 3) ? m_cs : 2'b11;
            check(cur_req, {30'd0, cs_n}, {30'd0, ecs}, "cs_n");
            check("R5", {31'd0, sh_start}, {31'd0, m_ph == 1}, "sh_start");
            check("R5", {31'd0, wr_ready}, {31'd0, m_ph == 0 || m_ph == 3}, "wr_ready");
            if (sh_start) check("R1", {16'd0, sh_data}, {16'd0, m_data}, "sh_data");
        end
        sh_done = 1'b0;
        if (stray) sh_done = 1'b1;
        if (shift_left > 0) begin
            shift_left--;
            if (shift_left == 0) sh_done = 1'b1;
        end
        if (sh_start) shift_left = 3;
    end

    task automatic send(input logic [3:0] code, input bit last, input logic [15:0] data, input logic [3:0] junk);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_word  = {7'd0, last, junk, code, data};
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_word  = '0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", {30'd0, cs_n}, 32'd3, "cs_n in reset");
        check("R9", {31'd0, sh_start}, 32'd0, "sh_start in reset");
        check("R9", {31'd0, wr_ready}, 32'd1, "wr_ready in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {30'd0, cs_n}, 32'd3, "cs_n after reset");

        // R3: fixed map, no hold; R6 also covered by last flag set
        cur_req = "R3";
        send(4'h0, 1'b0, 16'h00A5, 4'h0);
        send(4'h2, 1'b1, 16'h1234, 4'hF);
        send(4'h1, 1'b0, 16'hFFFF, 4'h0);
        send(4'h3, 1'b0, 16'h0001, 4'h0);
        settle();
        cur_req = "R6";
        send(4'h1, 1'b1, 16'h8001, 4'h0);
        send(4'h1, 1'b0, 16'h4002, 4'h0);
        settle();

        // R4: direct drive
        dec_en  = 1'b1;
        cur_req = "R4";
        send(4'h1, 1'b0, 16'h0011, 4'h0);
        send(4'h2, 1'b0, 16'h0022, 4'h0);
        send(4'h3, 1'b0, 16'h0033, 4'h0);
        send(4'hC, 1'b0, 16'h0044, 4'h0);
        settle();
        dec_en = 1'b0;

        // R7: hold across words, closed by last
        hold_en = 1'b1;
        cur_req = "R7";
        send(4'h1, 1'b0, 16'h0101, 4'h0);
        send(4'h1, 1'b0, 16'h0202, 4'h0);
        send(4'h1, 1'b1, 16'h0303, 4'h0);
        settle();
        check("R7", {30'd0, cs_n}, 32'd3, "cs_n after last word");

        // R8: switch peripheral while held
        cur_req = "R8";
        send(4'h0, 1'b0, 16'hAAAA, 4'h0);
        send(4'h1, 1'b0, 16'h5555, 4'h0);
        send(4'h0, 1'b1, 16'h0F0F, 4'h0);
        settle();

        // R2: static select, word fields ignored
        var_sel_en = 1'b0;
        fixed_sel  = 4'h1;
        cur_req    = "R2";
        send(4'h0, 1'b1, 16'h0A0A, 4'h0);
        send(4'h2, 1'b1, 16'h0B0B, 4'h0);
        settle();
        check("R2", {30'd0, cs_n}, 32'd1, "cs_n held despite last flag");
        var_sel_en = 1'b1;
        send(4'h1, 1'b1, 16'h0C0C, 4'h0);
        settle();

        // R10: stray done while held and while idle
        cur_req = "R10";
        send(4'h0, 1'b0, 16'h1111, 4'h0);
        settle();
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", {30'd0, cs_n}, 32'd2, "held cs_n after stray done");
        send(4'h0, 1'b1, 16'h2222, 4'h0);
        settle();
        hold_en = 1'b0;
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", {31'd0, wr_ready}, 32'd1, "ready after idle stray done");
        check("R10", {30'd0, cs_n}, 32'd3, "idle cs_n after stray done");
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule